// File: doc/BRIEF.md
# Half-Precision Fused Multiply-Add Unit

This block computes A×B+C on three 16-bit floating-point operands and rounds the result only once. The product of the two significands is kept exact and is never rounded by itself. It is placed next to the addend in one wide fixed-point window and added or subtracted there. Only after that is the exact sum normalized and rounded to nearest, with ties going to even. Because of this, results that depend on the low bits of the product come out correct, and a separate multiply followed by an add would lose those bits.

Every word uses the same layout: sign in bit 15, a biased exponent field in bits 14:10 with bias 15, and a stored fraction in bits 9:0. An exponent field of 0 means zero or a subnormal value, with effective exponent −14 and no hidden bit. A field of 31 means infinity when the fraction is zero and NaN otherwise. The pipeline accepts one operation per clock when `in_valid` is high. It delivers the result with `out_valid` a fixed four cycles later.

Top module: `fma16_unit`

## Requirements
- R1: For finite operands, a valid result equals A×B+C rounded once to the nearest 16-bit value, with sign in bit 15, exponent field in bits 14:10 (bias 15) and fraction in bits 9:0.
- R2: The product is not rounded before the addition. For example, 0x3C01×0x3C01+0xBC02 gives 0x0010 (2^-20), not 0.
- R3: Rounding is to nearest, ties to even. A round-up that carries out of the significand increments the exponent. For example, 0x3BFF×0x3C00+0x0C00 gives 0x3C00.
- R4: Subnormal operands (exponent field 0) take part at full precision, and results below 2^-14 are delivered as subnormals or zero with the same tie-to-even rule.
- R5: A finite result whose rounded magnitude exceeds 65504 becomes infinity of the result's sign (0x7C00 or 0xFC00).
- R6: Any NaN operand, infinity times zero, or an infinite product plus an infinite addend of opposite sign gives the quiet NaN 0x7E00.
- R7: An infinite product or infinite addend, where R6 does not apply, gives infinity with the sign of the infinite term.
- R8: An exact zero sum gives +0 (0x0000) when the product and addend have opposite signs, and keeps the common sign when both are zeros of the same sign.
- R9: `out_valid` is high exactly four clock cycles after each cycle in which `in_valid` was high, and low otherwise. Operations may be issued every cycle, and cycles with `in_valid` low produce no output.
- R10: While `rst` is high, and after it, `out_valid` and `out_result` are 0 until a new operation reaches the output. Operations in flight when reset is applied are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands on this cycle form a new operation |
| in_a | input | 16 | Multiplicand A |
| in_b | input | 16 | Multiplier B |
| in_c | input | 16 | Addend C |
| out_valid | output | 1 | `out_result` holds a finished operation |
| out_result | output | 16 | Rounded A×B+C |

## Verification
The latency property assumes that `in_valid` is a clean 0 or 1 on every clock edge after reset. It also assumes that reset is held for whole cycles, so the four-cycle window it checks never straddles a reset. The NaN and field-encoding properties rely only on the output being driven from registers. They therefore make no assumption about operand values, and the stimulus may use any bit pattern, NaN payloads included. The bench drives inputs only on falling edges, keeps `in_valid` at 0 or 1, and applies reset across whole cycles. It also fills idle cycles with NaN and infinity patterns, so that any leak from an idle cycle to the output would be seen.

// File: rtl/fma16_pkg.sv
`timescale 1ns/1ps
package fma16_pkg;
  localparam int DEF_EXP_W  = 5;
  localparam int DEF_FRAC_W = 10;

  typedef struct packed {
    logic nan;
    logic inf;
    logic inf_sign;
  } spec_t;
endpackage

// File: rtl/fma16_sigmul.sv
`timescale 1ns/1ps
// Array multiplier: one conditional row add per multiplier bit.
module fma16_sigmul #(
  parameter int N = 11
) (
  input  logic [N-1:0]   a,
  input  logic [N-1:0]   b,
  output logic [2*N-1:0] p
);
  logic [2*N-1:0] acc [N+1];

  assign acc[0] = '0;
  for (genvar i = 0; i < N; i++) begin : g_row
    assign acc[i+1] = acc[i] + (b[i] ? ((2*N)'(a) << i) : '0);
  end
  assign p = acc[N];
endmodule

// File: rtl/fma16_align_add.sv
`timescale 1ns/1ps
// Places product and addend in one exact window and forms the signed-magnitude sum.
module fma16_align_add #(
  parameter int SW  = 11,
  parameter int WIN = 82,
  parameter int SHW = 7
) (
  input  logic [2*SW-1:0] prod,
  input  logic [SHW-1:0]  psh,
  input  logic [SW-1:0]   addend,
  input  logic [SHW-1:0]  csh,
  input  logic            sp,
  input  logic            sc,
  output logic [WIN-1:0]  sum,
  output logic            sign
);
  logic [WIN-1:0] pw, cw;

  always_comb begin
    pw = WIN'(prod) << psh;
    cw = WIN'(addend) << csh;
    if (sp == sc) begin
      sum  = pw + cw;
      sign = sp;
    end else if (pw >= cw) begin
      sum  = pw - cw;
      sign = sp;
    end else begin
      sum  = cw - pw;
      sign = sc;
    end
    // exact cancellation of opposite-sign terms yields +0 (R8)
    if (sum == '0 && sp != sc) sign = 1'b0;
  end
endmodule

// File: rtl/fma16_round.sv
`timescale 1ns/1ps
// Normalizes the exact sum and rounds it once, to nearest with ties to even.
module fma16_round #(
  parameter int EW   = 5,
  parameter int MW   = 10,
  parameter int WIN  = 82,
  parameter int SUBQ = 24
) (
  input  logic [WIN-1:0]   sum,
  input  logic             sign,
  output logic [EW+MW:0]   res
);
  localparam int SW    = MW + 1;
  localparam int SW1   = SW + 1;
  localparam int EMAXF = (1 << EW) - 1;

  int             lead, q, fld;
  logic [SW-1:0]  mant;
  logic [SW:0]    mr;
  logic [WIN-1:0] mask;
  logic           rb, st;

  always_comb begin
    lead = 0;
    for (int i = 0; i < WIN; i++) begin
      if (sum[i]) lead = i;
    end
    q    = (lead - MW > SUBQ) ? lead - MW : SUBQ;
    mant = SW'(sum >> q);
    rb   = sum[q-1];
    mask = (WIN'(1) << (q - 1)) - WIN'(1);
    st   = |(sum & mask);
    mr   = {1'b0, mant} + SW1'(rb & (st | mant[0]));
    if (mr[SW]) begin
      mr = mr >> 1;
      q  = q + 1;
    end
    fld = mr[SW-1] ? q - SUBQ + 1 : 0;
    if (fld >= EMAXF) res = {sign, {EW{1'b1}}, {MW{1'b0}}};
    else              res = {sign, EW'(fld), mr[MW-1:0]};
  end
endmodule

// File: rtl/fma16_unit.sv
`timescale 1ns/1ps
module fma16_unit
  import fma16_pkg::*;
#(
  parameter int EW = DEF_EXP_W,
  parameter int MW = DEF_FRAC_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_valid,
  input  logic [EW+MW:0]   in_a,
  input  logic [EW+MW:0]   in_b,
  input  logic [EW+MW:0]   in_c,
  output logic             out_valid,
  output logic [EW+MW:0]   out_result
);
  localparam int FW      = 1 + EW + MW;
  localparam int SW      = MW + 1;
  localparam int BIAS    = (1 << (EW - 1)) - 1;
  localparam int EMAXF   = (1 << EW) - 1;
  localparam int WLSB    = 2 * (BIAS - 1) + 2 * MW;       // window bit 0 weight 2^-WLSB
  localparam int SUBQ    = WLSB - (BIAS - 1) - MW;        // window index of subnormal lsb
  localparam int WIN     = 2 * (EMAXF - 1) - 2 * BIAS - 2 * MW + WLSB + 2 * SW + 2;
  localparam int SHW     = $clog2(WIN);
  localparam int PSH_ADJ = WLSB - 2 * BIAS - 2 * MW;
  localparam int CSH_ADJ = WLSB - BIAS - MW;
  localparam logic [FW-1:0] QNAN = {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}};

  // stage 1: operand capture
  logic          v1;
  logic [FW-1:0] opq [3];

  always_ff @(posedge clk) begin
    if (rst) v1 <= 1'b0;
    else     v1 <= in_valid;
    opq[0] <= in_a;
    opq[1] <= in_b;
    opq[2] <= in_c;
  end

  // stage 2: unpack, multiply, classify
  logic [EW-1:0] ef [3];
  logic [MW-1:0] ff [3];
  logic [SW-1:0] sg [3];
  logic [EW-1:0] eb [3];
  logic          sn [3];
  logic          isinf [3];
  logic          isnan [3];
  logic          iszero [3];

  for (genvar k = 0; k < 3; k++) begin : g_unp
    assign sn[k]     = opq[k][FW-1];
    assign ef[k]     = opq[k][FW-2:MW];
    assign ff[k]     = opq[k][MW-1:0];
    assign sg[k]     = {|ef[k], ff[k]};
    assign eb[k]     = (|ef[k]) ? ef[k] : EW'(1);
    assign isinf[k]  = (&ef[k]) && (ff[k] == '0);
    assign isnan[k]  = (&ef[k]) && (|ff[k]);
    assign iszero[k] = (sg[k] == '0);
  end

  logic [2*SW-1:0] prod_c;
  logic [SHW-1:0]  psh_c, csh_c;
  logic            sp_c, infp_c;
  spec_t           spec_c;

  fma16_sigmul #(.N(SW)) u_mul (.a(sg[0]), .b(sg[1]), .p(prod_c));

  assign psh_c  = SHW'(int'(eb[0]) + int'(eb[1]) + PSH_ADJ);
  assign csh_c  = SHW'(int'(eb[2]) + CSH_ADJ);
  assign sp_c   = sn[0] ^ sn[1];
  assign infp_c = isinf[0] | isinf[1];

  always_comb begin
    spec_c.nan = isnan[0] | isnan[1] | isnan[2]
               | (isinf[0] & iszero[1]) | (isinf[1] & iszero[0])
               | (infp_c & isinf[2] & (sp_c != sn[2]));
    spec_c.inf      = infp_c | isinf[2];
    spec_c.inf_sign = infp_c ? sp_c : sn[2];
  end

  logic            v2, sp_q, sc_q;
  logic [2*SW-1:0] prod_q;
  logic [SHW-1:0]  psh_q, csh_q;
  logic [SW-1:0]   csig_q;
  spec_t           spec2;

  always_ff @(posedge clk) begin
    if (rst) v2 <= 1'b0;
    else     v2 <= v1;
    prod_q <= prod_c;
    psh_q  <= psh_c;
    csig_q <= sg[2];
    csh_q  <= csh_c;
    sp_q   <= sp_c;
    sc_q   <= sn[2];
    spec2  <= spec_c;
  end

  // stage 3: align and add
  logic [WIN-1:0] sum_c, sum_q;
  logic           sgn_c, sgn_q, v3;
  spec_t          spec3;

  fma16_align_add #(.SW(SW), .WIN(WIN), .SHW(SHW)) u_add (
    .prod(prod_q), .psh(psh_q), .addend(csig_q), .csh(csh_q),
    .sp(sp_q), .sc(sc_q), .sum(sum_c), .sign(sgn_c)
  );

  always_ff @(posedge clk) begin
    if (rst) v3 <= 1'b0;
    else     v3 <= v2;
    sum_q <= sum_c;
    sgn_q <= sgn_c;
    spec3 <= spec2;
  end

  // stage 4: normalize, round, special override
  logic [FW-1:0] rnd_c, fin_c;

  fma16_round #(.EW(EW), .MW(MW), .WIN(WIN), .SUBQ(SUBQ)) u_rnd (
    .sum(sum_q), .sign(sgn_q), .res(rnd_c)
  );

  always_comb begin
    if (spec3.nan)      fin_c = QNAN;
    else if (spec3.inf) fin_c = {spec3.inf_sign, {EW{1'b1}}, {MW{1'b0}}};
    else                fin_c = rnd_c;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid  <= 1'b0;
      out_result <= '0;
    end else begin
      out_valid <= v3;
      if (v3) out_result <= fin_c;
    end
  end
endmodule

// File: rtl/fma16_unit_chk.sv
`timescale 1ns/1ps
module fma16_unit_chk #(
  parameter int FW = 16,
  parameter int MW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          out_valid,
  input logic [FW-1:0] out_result
);
  localparam int EW = FW - 1 - MW;

  logic [2:0] since_rst;
  always_ff @(posedge clk) begin
    if (rst)                since_rst <= '0;
    else if (since_rst < 4) since_rst <= since_rst + 3'd1;
  end

  // R9: output strobe follows the input strobe by exactly four cycles
  a_r9_latency: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= 3'd4) |-> (out_valid == $past(in_valid, 4)));

  // R10: first cycle after reset shows nothing valid
  a_r10_reset_clears: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (!out_valid && out_result == '0));

  // R6: every NaN leaving the unit is the canonical quiet NaN
  a_r6_canonical_nan: assert property (@(posedge clk) disable iff (rst)
    (out_valid && (&out_result[FW-2:MW]) && (|out_result[MW-1:0]))
      |-> (out_result == {1'b0, {EW{1'b1}}, 1'b1, {(MW-1){1'b0}}}));

  // R1: a valid result is fully known
  a_r1_known_result: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !$isunknown(out_result));
endmodule

bind fma16_unit fma16_unit_chk #(.FW(1 + EW + MW), .MW(MW)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid),
  .out_valid(out_valid), .out_result(out_result)
);

// File: tb/fma16_unit_test.sv
`timescale 1ns/1ps
module fma16_unit_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [15:0] in_a = '0, in_b = '0, in_c = '0;
  logic        out_valid;
  logic [15:0] out_result;

  always #2 clk = ~clk;

  fma16_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .in_a(in_a), .in_b(in_b), .in_c(in_c),
    .out_valid(out_valid), .out_result(out_result)
  );

  // {A, B, C, expected}
  localparam int NV = 28;
  localparam logic [63:0] VEC [NV] = '{
    64'h3C00_3C00_3C00_4000, // R1 1*1+1
    64'h4000_4200_3C00_4700, // R1 2*3+1
    64'h4000_4200_C700_BC00, // R1 2*3-7
    64'h4400_3800_4200_4500, // R1 4*0.5+3
    64'h3C01_3C01_BC02_0010, // R2 exact product survives cancellation
    64'h3C00_3C00_1000_3C00, // R3 tie, even stays
    64'h3C00_3C00_1200_3C01, // R3 above half rounds up
    64'h3BFF_3C00_0C00_3C00, // R3 carry into exponent
    64'h0001_3800_0000_0000, // R4 half of min subnormal, tie to 0
    64'h0003_3800_0000_0002, // R4 1.5 ulp tie to 2
    64'h0001_3C00_0001_0002, // R4 subnormal sum
    64'h0400_3800_0000_0200, // R4 normal inputs, subnormal result
    64'h7BFF_4000_0000_7C00, // R5 overflow +
    64'h7BFF_3C00_0000_7BFF, // R5 max finite kept
    64'hFBFF_4000_0000_FC00, // R5 overflow -
    64'h7C00_0000_3C00_7E00, // R6 inf*0
    64'h7C00_3C00_FC00_7E00, // R6 inf-inf
    64'h3C00_7D00_0000_7E00, // R6 NaN operand
    64'h3C00_3C00_7E55_7E00, // R6 NaN addend payload
    64'h7C00_3C00_3C00_7C00, // R7 +inf product
    64'hFC00_3C00_4500_FC00, // R7 -inf product
    64'h3C00_3C00_FC00_FC00, // R7 -inf addend
    64'h3C00_3C00_BC00_0000, // R8 x-x
    64'h8000_3C00_8000_8000, // R8 -0 + -0
    64'h0000_3C00_8000_0000, // R8 +0 + -0
    64'h4000_4200_C600_0000, // R8 6-6
    64'h4000_4200_0001_4600, // R1 tiny addend absorbed
    64'hC000_4200_0001_C600  // R1 tiny addend absorbed, negative
  };
  localparam logic [23:0] TAG [NV] = '{
    "R1 ","R1 ","R1 ","R1 ","R2 ","R3 ","R3 ","R3 ",
    "R4 ","R4 ","R4 ","R4 ","R5 ","R5 ","R5 ","R6 ",
    "R6 ","R6 ","R6 ","R7 ","R7 ","R7 ","R8 ","R8 ",
    "R8 ","R8 ","R1 ","R1 "
  };

  int          nchk = 0, nfail = 0, cyc = 0;
  logic        hv [8];
  logic [15:0] he [8];
  logic [23:0] ht [8];

  task automatic tick(input logic v, input logic [15:0] a, input logic [15:0] b,
                      input logic [15:0] c, input logic [15:0] e, input logic [23:0] t);
    int s;
    @(negedge clk);
    if (cyc >= 4) begin
      s = (cyc - 4) % 8;
      nchk++;
      if (out_valid !== hv[s] || (hv[s] && out_result !== he[s])) begin
        nfail++;
        $display("FAIL %s: valid=%b result=%h expected valid=%b result=%h",
                 ht[s], out_valid, out_result, hv[s], he[s]);
      end
    end
    in_valid = v; in_a = a; in_b = b; in_c = c;
    s = cyc % 8;
    hv[s] = v; he[s] = e; ht[s] = v ? t : "R9 ";
    cyc++;
  endtask

  task automatic idle();
    tick(1'b0, 16'h7C00, 16'h7E00, 16'hFFFF, 16'h0000, "R9 ");
  endtask

  task automatic restart();
    cyc = 0;
    for (int k = 0; k < 8; k++) hv[k] = 1'b0;
  endtask

  initial begin
    restart();
    // R10: outputs cleared while reset is held
    repeat (3) @(negedge clk);
    nchk++;
    if (out_valid !== 1'b0 || out_result !== 16'h0000) begin
      nfail++;
      $display("FAIL R10: valid=%b result=%h expected valid=0 result=0000", out_valid, out_result);
    end
    rst = 1'b0;

    // table walk with idle bubbles (R9)
    for (int i = 0; i < NV; i++) begin
      tick(1'b1, VEC[i][63:48], VEC[i][47:32], VEC[i][31:16], VEC[i][15:0], TAG[i]);
      if (i % 5 == 4) idle();
    end
    repeat (5) idle();

    // R10: reset with operations in flight discards them
    tick(1'b1, 16'h3C00, 16'h3C00, 16'h3C00, 16'h4000, "R10");
    tick(1'b1, 16'h4000, 16'h4200, 16'h3C00, 16'h4700, "R10");
    @(negedge clk);
    in_valid = 1'b0;
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int j = 0; j < 6; j++) begin
      @(negedge clk);
      nchk++;
      if (out_valid !== 1'b0 || out_result !== 16'h0000) begin
        nfail++;
        $display("FAIL R10: valid=%b result=%h expected valid=0 result=0000", out_valid, out_result);
      end
    end

    // recovery after reset, back-to-back issue (R9)
    restart();
    tick(1'b1, 16'h4400, 16'h3800, 16'h4200, 16'h4500, "R9 ");
    tick(1'b1, 16'h3C01, 16'h3C01, 16'hBC02, 16'h0010, "R2 ");
    tick(1'b1, 16'h7BFF, 16'h4000, 16'h0000, 16'h7C00, "R5 ");
    repeat (5) idle();

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule